// File: doc/BRIEF.md
# Paged Boot ROM Address Mapper

This block sits between the CPU and a 128K x 8 flash boot ROM. It turns the top three CPU address lines and the contents of a small page register into the upper flash address lines A16..A13, and it drives the ROM enable. The flash holds two complete 64K ROM sets with the same internal layout of eight 8K images. A static configuration switch picks the set through A16. Within a set, the lowest 8K image is the operating system. The remaining images are paged ROMs that appear in the second 8K of the CPU address space.

Software writes the page register through an I/O write strobe. Its top bit disconnects the ROMs so that RAM decode can own the low 16K. Its next three bits choose a logical page. The logical page number is not the physical slot number: the mapper reorders them, and it refuses two page numbers outright, so those pages read as no ROM at all. The configuration switch passes through a synchronizer and is captured only while reset is held, so the ROM set cannot change under running code. All pins are plain control and address lines, with no streaming handshake.

Top module: `rom_page_mapper`

## Requirements
- R1: All registers reset synchronously while rst_n is low. After reset the page register is zero, so the ROMs are paged in and logical page 0 is selected.
- R2: rom_a[3] (flash A16) equals the switch level that was present during the last reset, once that level has been stable for at least three clocks of reset. Changes of set_sw after reset have no effect until the next reset.
- R3: With the ROMs paged in, a memory read at CPU addresses 0000h-1FFFh (cpu_a_hi = 000) asserts rom_en with rom_a[2:0] = 000.
- R4: With the ROMs paged in, a memory read at 2000h-3FFFh (cpu_a_hi = 001) asserts rom_en. rom_a[2:0] follows logical page 0 to 010, 1 to 001, 3 to 100, 4 to 101, 5 to 110 and 6 to 111.
- R5: Logical pages 2 and 7 are blocked. A read in the paged window with either page selected leaves rom_en low.
- R6: When the page register's disconnect bit is 1, rom_en stays low at every address.
- R7: rom_en stays low for CPU addresses 4000h and above (cpu_a_hi[2:1] not 00).
- R8: rom_en is asserted only when mem_rd is 1 and mem_wr is 0. A write, or an idle bus, never asserts it.
- R9: A clock edge with port_wr high loads port_d_hi into the page register. port_d_hi[3] is the disconnect bit and port_d_hi[2:0] is the page number, with bit 0 as LSB. The new value governs decode from the cycle after that edge. A read in the same cycle as the write uses the old value.
- R10: rom_a[2:0] is 000 whenever rom_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_a_hi | input | 3 | CPU address lines A15..A13 |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| port_wr | input | 1 | I/O write strobe for the page register |
| port_d_hi | input | 4 | Data bus bits D7..D4 during a page-register write |
| set_sw | input | 1 | Static ROM-set select switch |
| rom_a | output | 4 | Flash address lines A16..A13 |
| rom_en | output | 1 | Flash chip enable, active high |

## Verification
A page-register write and a paged-window read can fall in the same cycle, and the read must then see the page that was current before the write. The bench drives port_wr and mem_rd together at 2000h with a new page value. It judges the outputs before the edge against the old page and after the edge against the new one. This includes cases that move from an open page to a blocked page and back.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

  // Three upper address lines select one of eight 8K windows / slots.
  localparam int PAGE_W = 3;
  localparam int NUM_PAGES = 1 << PAGE_W;

  typedef logic [PAGE_W-1:0] slot_t;

  // Logical page number to physical 8K slot inside one 64K set.
  // Slot 0 belongs to the OS image, so pages are pushed up by one,
  // except that pages 0 and 1 trade places.
  function automatic slot_t page_to_slot(input slot_t pg);
    slot_t r;
    if (pg == slot_t'(0))      r = slot_t'(2);
    else if (pg == slot_t'(1)) r = slot_t'(1);
    else                       r = pg + slot_t'(1);
    return r;
  endfunction

endpackage

// File: rtl/rpm_set_sync.sv
module rpm_set_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_in,
  output logic set_o
);

  logic [STAGES-1:0] sync_q;
  logic              set_q;

  // Free-running synchronizer; it must keep sampling during reset.
  always_ff @(posedge clk) begin
    sync_q <= {sync_q[STAGES-2:0], sw_in};
  end

  // Set choice is frozen at the synchronized level seen during reset.
  always_ff @(posedge clk) begin
    if (!rst_n) set_q <= sync_q[STAGES-1];
  end

  assign set_o = set_q;

endmodule

// File: rtl/rpm_page_reg.sv
module rpm_page_reg
  import rpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [3:0]  d,
  output logic        ctl_o,
  output slot_t       page_o
);

  logic  ctl_q;
  slot_t page_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= 1'b0;
      page_q <= '0;
    end else if (wr) begin
      ctl_q  <= d[3];
      page_q <= d[2:0];
    end
  end

  assign ctl_o  = ctl_q;
  assign page_o = page_q;

endmodule

// File: rtl/rpm_window_decode.sv
module rpm_window_decode
  import rpm_pkg::*;
#(
  parameter logic [NUM_PAGES-1:0] BLOCK_MASK = 8'b1000_0100
) (
  input  logic        [PAGE_W-1:0] a_hi,
  input  logic                     mem_rd,
  input  logic                     mem_wr,
  input  logic                     ctl,
  input  slot_t                    page,
  input  logic                     set,
  output logic        [PAGE_W:0]   rom_a,
  output logic                     rom_en
);

  localparam slot_t OS_SLOT = '0;

  slot_t                slot_tab [NUM_PAGES];
  logic [NUM_PAGES-1:0] open_tab;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    assign slot_tab[p] = page_to_slot(slot_t'(p));
    assign open_tab[p] = ~BLOCK_MASK[p];
  end

  logic  rd_ok;
  logic  low16k;
  logic  in_paged;
  logic  en_c;
  slot_t slot_c;

  assign rd_ok    = mem_rd & ~mem_wr & ~ctl;
  assign low16k   = (a_hi[PAGE_W-1:1] == '0);
  assign in_paged = a_hi[0];

  always_comb begin
    en_c   = 1'b0;
    slot_c = OS_SLOT;
    if (rd_ok && low16k) begin
      if (!in_paged) begin
        en_c   = 1'b1;
        slot_c = OS_SLOT;
      end else if (open_tab[page]) begin
        en_c   = 1'b1;
        slot_c = slot_tab[page];
      end
    end
  end

  assign rom_en = en_c;
  assign rom_a  = {set, slot_c};

endmodule

// File: rtl/rom_page_mapper.sv
module rom_page_mapper
  import rpm_pkg::*;
#(
  parameter int                   SYNC_STAGES = 2,
  parameter logic [NUM_PAGES-1:0] BLOCK_MASK  = 8'b1000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] cpu_a_hi,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              port_wr,
  input  logic [3:0]        port_d_hi,
  input  logic              set_sw,
  output logic [PAGE_W:0]   rom_a,
  output logic              rom_en
);

  logic  set_q;
  logic  ctl_q;
  slot_t page_q;

  rpm_set_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .sw_in (set_sw),
    .set_o (set_q)
  );

  rpm_page_reg u_preg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (port_wr),
    .d      (port_d_hi),
    .ctl_o  (ctl_q),
    .page_o (page_q)
  );

  rpm_window_decode #(.BLOCK_MASK(BLOCK_MASK)) u_dec (
    .a_hi   (cpu_a_hi),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .ctl    (ctl_q),
    .page   (page_q),
    .set    (set_q),
    .rom_a  (rom_a),
    .rom_en (rom_en)
  );

endmodule

// File: rtl/rpm_checker.sv
module rpm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cpu_a_hi,
  input logic       mem_wr,
  input logic       mem_rd,
  input logic       port_wr,
  input logic [3:0] port_d_hi,
  input logic [3:0] rom_a,
  input logic       rom_en,
  input logic       ctl,
  input logic [2:0] page
);

  // R8
  wr_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || !mem_rd) |-> !rom_en);

  // R6
  disconnect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl |-> !rom_en);

  // R7
  high_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_a_hi[2:1] != 2'b00) |-> !rom_en);

  // R5
  blocked_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_a_hi == 3'b001) && (page == 3'd2 || page == 3'd7)) |-> !rom_en);

  // R10
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_en |-> (rom_a[2:0] == 3'b000));

  // R2
  set_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(rom_a[3]));

  // R9
  port_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> ({ctl, page} == $past(port_d_hi)));

  // R3
  os_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_wr && !ctl && cpu_a_hi == 3'b000) |-> (rom_en && rom_a[2:0] == 3'b000));

endmodule

bind rom_page_mapper rpm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_a_hi  (cpu_a_hi),
  .mem_wr    (mem_wr),
  .mem_rd    (mem_rd),
  .port_wr   (port_wr),
  .port_d_hi (port_d_hi),
  .rom_a     (rom_a),
  .rom_en    (rom_en),
  .ctl       (ctl_q),
  .page      (page_q)
);

// File: tb/test_rom_page_mapper.sv
module test_rom_page_mapper;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cpu_a_hi = '0;
  logic       mem_rd = 1'b0;
  logic       mem_wr = 1'b0;
  logic       port_wr = 1'b0;
  logic [3:0] port_d_hi = '0;
  logic       set_sw = 1'b0;
  logic [3:0] rom_a;
  logic       rom_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rom_page_mapper i_rom_page_mapper (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_a_hi  (cpu_a_hi),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .port_wr   (port_wr),
    .port_d_hi (port_d_hi),
    .set_sw    (set_sw),
    .rom_a     (rom_a),
    .rom_en    (rom_en)
  );

  function automatic logic [2:0] exp_slot(input logic [2:0] pg);
    if (pg == 3'd0) return 3'd2;
    if (pg == 3'd1) return 3'd1;
    return pg + 3'd1;
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got en=%0b a=%04b expected en=%0b a=%04b",
               req, got[4], got[3:0], exp[4], exp[3:0]);
    end
  endtask

  task automatic do_reset(input logic sw);
    @(negedge clk);
    set_sw = sw;
    rst_n  = 1'b0;
    repeat (5) @(negedge clk);
    rst_n  = 1'b1;
  endtask

  task automatic write_port(input logic [7:0] v);
    port_wr   = 1'b1;
    port_d_hi = v[7:4];
    @(negedge clk);
    port_wr   = 1'b0;
  endtask

  // Drive a bus cycle, compute the expectation, compare.
  task automatic probe(input logic [15:0] addr, input logic rd, input logic wr,
                       input logic ctl, input logic [2:0] pg, input logic set,
                       input string tag);
    logic en;
    logic [2:0] sl;
    cpu_a_hi = addr[15:13];
    mem_rd   = rd;
    mem_wr   = wr;
    #1;
    en = rd && !wr && !ctl && (addr < 16'h4000) &&
         ((addr < 16'h2000) || (pg != 3'd2 && pg != 3'd7));
    sl = (!en || addr < 16'h2000) ? 3'd0 : exp_slot(pg);
    check(tag, {rom_en, rom_a}, {en, set, sl});
    @(negedge clk);
    mem_rd = 1'b0;
    mem_wr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      do_reset(s[0]);
      // R1: reset state is page 0, paged in
      probe(16'h0000, 1'b1, 1'b0, 1'b0, 3'd0, s[0], "R1 os after reset");
      probe(16'h2000, 1'b1, 1'b0, 1'b0, 3'd0, s[0], "R1 page0 after reset");
      for (int c = 0; c < 2; c++) begin
        for (int p = 0; p < 8; p++) begin
          write_port({c[0], p[2:0], 4'h5});
          for (int a = 0; a < 8; a++) begin
            for (int m = 0; m < 4; m++) begin
              logic [15:0] addr;
              string tag;
              addr = {a[2:0], 13'h0} + ((m == 3) ? 16'h1FFF : 16'h0);
              if (m[0] == 1'b0 || m == 3 && 1'b0) tag = "R8";
              else if (c == 1) tag = "R6";
              else if (a >= 2) tag = "R7";
              else if (a == 0) tag = "R3";
              else if (p == 2 || p == 7) tag = "R5";
              else tag = "R4";
              // m: 0 idle, 1 read, 2 write, 3 read at window top
              probe(addr, m[0], (m == 2), c[0], p[2:0], s[0], tag);
            end
            // R8: read and write together never enable
            probe({a[2:0], 13'h0}, 1'b1, 1'b1, c[0], p[2:0], s[0], "R8 rd+wr");
          end
        end
      end
    end

    // R2: switch movement after reset is ignored
    do_reset(1'b1);
    write_port(8'h00);
    set_sw = 1'b0;
    repeat (8) @(negedge clk);
    probe(16'h0000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R2 frozen set");
    probe(16'h2000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R2 frozen set paged");
    probe(16'h8000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, "R10 R2 idle slot");
    do_reset(1'b0);
    probe(16'h0000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, "R2 new set after reset");

    // R9: page write and paged read in the same cycle
    for (int o = 0; o < 8; o++) begin
      for (int n = 0; n < 8; n++) begin
        write_port({1'b0, o[2:0], 4'h0});
        port_wr   = 1'b1;
        port_d_hi = {1'b0, n[2:0]};
        cpu_a_hi  = 3'b001;
        mem_rd    = 1'b1;
        #1;
        check("R9 old page same cycle", {rom_en, rom_a},
              (o == 2 || o == 7) ? 5'b0_0000 : {1'b1, 1'b0, exp_slot(o[2:0])});
        @(negedge clk);
        port_wr = 1'b0;
        #1;
        check("R9 new page next cycle", {rom_en, rom_a},
              (n == 2 || n == 7) ? 5'b0_0000 : {1'b1, 1'b0, exp_slot(n[2:0])});
        @(negedge clk);
        mem_rd = 1'b0;
      end
    end

    // R9 R6: disconnect bit written alongside a read
    write_port(8'h10);
    port_wr = 1'b1; port_d_hi = 4'b1001; cpu_a_hi = 3'b000; mem_rd = 1'b1;
    #1;
    check("R9 ctl old", {rom_en, rom_a}, 5'b1_0000);
    @(negedge clk);
    port_wr = 1'b0;
    #1;
    check("R6 R9 ctl new", {rom_en, rom_a}, 5'b0_0000);
    @(negedge clk);
    mem_rd = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule